// File: doc/BRIEF.md
# Reloadable Down-Counting Event Timer

This block is one 32-bit event timer channel behind a small register bank. Software loads a count, picks a clock source and a power-of-two prescale, and enables the channel. The counter then steps down by one on every prescaled tick. When a tick arrives while the count is already zero, the channel expires and sets a status flag. In periodic mode it also reloads from a separate interval register. In one-shot mode it holds at zero and turns itself off.

The current count is writable as well as the interval. This lets software arm a first delay of one length and then keep a different period after it. The status flag is cleared by writing a one to it. A separate enable register gates the flag onto a level interrupt line. The two clock sources arrive as single-cycle pulse strobes that are synchronous to the register clock. The register bus is a plain single-cycle select/write strobe with read data returned one cycle later.

Top module: `evt_timer`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: While the control enable bit (bit 0 of offset 0x10) is set, the current count (offset 0x18) drops by one on each prescaled tick. While that bit is clear, the count holds.
- R3: The control field at bits [6:4] holds a prescale code c, and one tick is produced for every 2^c source pulses.
- R4: A tick that arrives while the count is zero is an expiry. An expiry sets bit 0 of the status register (offset 0x04). With control bit 1 set (periodic), the expiry also loads the count from the interval register (offset 0x14). A loaded value N therefore expires on the (N+1)-th tick.
- R5: Writing a 1 to status bit 0 clears it, and writing a 0 leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R6: `irq_o` is a registered copy of status bit 0 ANDed with interrupt-enable bit 0 (offset 0x00). It rises one cycle after both are set and stays high until one of them falls.
- R7: Control bit 2 set selects `osc_pulse_i` as the tick source, and clear selects `ref_pulse_i`. Pulses on the unselected input have no effect.
- R8: The prescaler restarts its count whenever the enable bit is low. After enabling, the first tick needs a full 2^c source pulses.
- R9: In one-shot mode (control bit 1 clear), an expiry holds the count at zero and clears the control enable bit.
- R10: A write to offset 0x18 loads the count directly. It takes priority over a tick in the same cycle.
- R11: A read returns the addressed register on `bus_rdata_o` one cycle after the request. Control reads back with enable at bit 0, periodic at bit 1, source select at bit 2 and the prescale code at [6:4]. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse_i | input | 1 | Single-cycle pulse strobe of the default clock source |
| osc_pulse_i | input | 1 | Single-cycle pulse strobe of the oscillator clock source |
| bus_sel_i | input | 1 | Register access request |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Level interrupt request |

## Verification
A register write, a source pulse and the resulting count change or expiry all land on the same clock edge. Read data appears on the edge that samples the read request, and `irq_o` follows the status flag one edge later. The bench applies every bus access and every source pulse between falling edges, so each one is seen at exactly one rising edge. A read's expected value goes into a queue when the read is issued, and the monitor compares it at the falling edge after the returning edge. The interrupt line is sampled only after a full read cycle has passed since the event that should move it. The same-edge priority cases (a count write against a tick, and a clearing write against an expiry) drive both stimuli inside one cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PSC_CODE_W = 3;

  localparam logic [7:0] OFF_IEN  = 8'h00;
  localparam logic [7:0] OFF_ISTA = 8'h04;
  localparam logic [7:0] OFF_CTRL = 8'h10;
  localparam logic [7:0] OFF_INTV = 8'h14;
  localparam logic [7:0] OFF_CUR  = 8'h18;

  localparam int BIT_EN  = 0;
  localparam int BIT_PER = 1;
  localparam int BIT_OSC = 2;
  localparam int BIT_PSC = 4;

  typedef struct packed {
    logic [PSC_CODE_W-1:0] psc;
    logic                  osc_sel;
    logic                  periodic;
    logic                  en;
  } ctrl_t;
endpackage

// File: rtl/tmr_psc.sv
module tmr_psc #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              src_pulse,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int DIV_W = (1 << CODE_W) - 1;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb lim = DIV_W'((32'd1 << code) - 32'd1);

  assign tick = en & src_pulse & (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (src_pulse) begin
      cnt <= (cnt == lim) ? '0 : cnt + DIV_W'(1);
    end
  end

  AST_PSC_RESTART: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0)); // R8

  AST_PSC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (en && src_pulse && (cnt != lim)) |=> (cnt == $past(cnt) + DIV_W'(1))); // R3
endmodule

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         periodic,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cur,
  output logic         expire
);
  logic at_zero;

  assign at_zero = (cur == '0);
  assign expire  = tick & at_zero & ~ld;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (ld) begin
      cur <= ld_val;
    end else if (tick) begin
      if (at_zero) cur <= periodic ? reload_val : '0;
      else         cur <= cur - W'(1);
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && (cur != '0)) |=> (cur == $past(cur) - W'(1))); // R2

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld) |=> $stable(cur)); // R2

  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && (cur == '0) && periodic) |=> (cur == $past(reload_val))); // R4

  AST_CNT_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && (cur == '0) && !periodic) |=> (cur == '0)); // R9

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cur == $past(ld_val))); // R10
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_pulse_i,
  input  logic              osc_pulse_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  import tmr_pkg::*;

  tmr_pkg::ctrl_t    ctrl_q;
  logic              ien_q;
  logic              sta_q;
  logic [DATA_W-1:0] intv_q;
  logic [DATA_W-1:0] cur;
  logic              expire;
  logic              tick;
  logic              src_pulse;
  logic              wr_en, rd_en;
  logic              hit_ien, hit_sta, hit_ctrl, hit_intv, hit_cur;
  logic [DATA_W-1:0] rd_mux;

  assign wr_en    = bus_sel_i & bus_wr_i;
  assign rd_en    = bus_sel_i & ~bus_wr_i;
  assign hit_ien  = (bus_addr_i == ADDR_W'(OFF_IEN));
  assign hit_sta  = (bus_addr_i == ADDR_W'(OFF_ISTA));
  assign hit_ctrl = (bus_addr_i == ADDR_W'(OFF_CTRL));
  assign hit_intv = (bus_addr_i == ADDR_W'(OFF_INTV));
  assign hit_cur  = (bus_addr_i == ADDR_W'(OFF_CUR));

  assign src_pulse = ctrl_q.osc_sel ? osc_pulse_i : ref_pulse_i;

  tmr_psc #(.CODE_W(PSC_CODE_W)) u_psc (
    .clk       (clk),
    .rst       (rst),
    .en        (ctrl_q.en),
    .src_pulse (src_pulse),
    .code      (ctrl_q.psc),
    .tick      (tick)
  );

  tmr_cnt #(.W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .periodic   (ctrl_q.periodic),
    .ld         (wr_en & hit_cur),
    .ld_val     (bus_wdata_i),
    .reload_val (intv_q),
    .cur        (cur),
    .expire     (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && hit_ctrl) begin
      ctrl_q.en       <= bus_wdata_i[BIT_EN];
      ctrl_q.periodic <= bus_wdata_i[BIT_PER];
      ctrl_q.osc_sel  <= bus_wdata_i[BIT_OSC];
      ctrl_q.psc      <= bus_wdata_i[BIT_PSC +: PSC_CODE_W];
    end else if (expire && !ctrl_q.periodic) begin
      ctrl_q.en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= 1'b0;
      intv_q <= '0;
    end else if (wr_en) begin
      if (hit_ien)  ien_q  <= bus_wdata_i[0];
      if (hit_intv) intv_q <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               sta_q <= 1'b0;
    else if (expire)                       sta_q <= 1'b1;
    else if (wr_en && hit_sta && bus_wdata_i[0]) sta_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= sta_q & ien_q;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ien) rd_mux[0] = ien_q;
    if (hit_sta) rd_mux[0] = sta_q;
    if (hit_ctrl) begin
      rd_mux[BIT_EN]                  = ctrl_q.en;
      rd_mux[BIT_PER]                 = ctrl_q.periodic;
      rd_mux[BIT_OSC]                 = ctrl_q.osc_sel;
      rd_mux[BIT_PSC +: PSC_CODE_W]   = ctrl_q.psc;
    end
    if (hit_intv) rd_mux = intv_q;
    if (hit_cur)  rd_mux = cur;
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata_o <= '0;
    else if (rd_en) bus_rdata_o <= rd_mux;
  end

  AST_STA_ON_EXPIRE: assert property (@(posedge clk) disable iff (rst)
    expire |=> sta_q); // R4

  AST_STA_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_sta && bus_wdata_i[0] && !expire) |=> !sta_q); // R5

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (sta_q && ien_q) |=> irq_o); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !(sta_q && ien_q) |=> !irq_o); // R6

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (expire && !ctrl_q.periodic && !(wr_en && hit_ctrl)) |=> !ctrl_q.en); // R9
endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_pulse = 1'b0;
  logic        osc_pulse = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  logic rd_pend = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  evt_timer u_dut (
    .clk         (clk),
    .rst         (rst),
    .ref_pulse_i (ref_pulse),
    .osc_pulse_i (osc_pulse),
    .bus_sel_i   (sel),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  always @(posedge clk) rd_pend <= sel & ~wr;

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (rdata !== e) begin
        miscompares++;
        $display("FAIL %s: read got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic pulse(input bit use_osc, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (use_osc) osc_pulse = 1'b1; else ref_pulse = 1'b1;
      @(negedge clk);
      osc_pulse = 1'b0; ref_pulse = 1'b0;
    end
  endtask

  task automatic write_and_pulse(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d; osc_pulse = 1'b1;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; osc_pulse = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    @(negedge clk);
    vectors++;
    if (irq !== e) begin
      miscompares++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  task automatic drain;
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(8'h00, 32'h0, "R1");
    bus_read(8'h04, 32'h0, "R1");
    bus_read(8'h10, 32'h0, "R1");
    bus_read(8'h14, 32'h0, "R1");
    bus_read(8'h18, 32'h0, "R1");
    chk_irq(1'b0, "R1");

    bus_write(8'h00, 32'h1);
    bus_write(8'h14, 32'd5);
    bus_write(8'h18, 32'd3);
    bus_read(8'h18, 32'd3, "R10");
    bus_write(8'h10, 32'h07);            // en, periodic, osc, code 0
    bus_read(8'h10, 32'h07, "R11");
    bus_read(8'h0C, 32'h0, "R11");       // unmapped offset
    pulse(1, 1);
    bus_read(8'h18, 32'd2, "R2");
    pulse(0, 2);                          // unselected source
    bus_read(8'h18, 32'd2, "R7");
    pulse(1, 3);                          // 2->1->0->expire, reload 5
    bus_read(8'h18, 32'd5, "R4");
    bus_read(8'h04, 32'h1, "R4");
    chk_irq(1'b1, "R6");

    bus_write(8'h04, 32'h0);
    bus_read(8'h04, 32'h1, "R5");
    bus_write(8'h04, 32'h1);
    bus_read(8'h04, 32'h0, "R5");
    chk_irq(1'b0, "R6");

    bus_write(8'h00, 32'h0);
    pulse(1, 6);                          // 5..0 then expire, reload 5
    bus_read(8'h04, 32'h1, "R4");
    chk_irq(1'b0, "R6");
    bus_write(8'h04, 32'h1);

    bus_write(8'h10, 32'h06);            // disabled
    pulse(1, 3);
    bus_read(8'h18, 32'd5, "R2");

    bus_write(8'h10, 32'h27);            // code 2: divide by 4
    pulse(1, 3);
    bus_read(8'h18, 32'd5, "R3");
    pulse(1, 1);
    bus_read(8'h18, 32'd4, "R3");
    pulse(1, 2);
    bus_write(8'h10, 32'h26);
    bus_write(8'h10, 32'h27);
    pulse(1, 3);
    bus_read(8'h18, 32'd4, "R8");
    pulse(1, 1);
    bus_read(8'h18, 32'd3, "R8");

    bus_write(8'h10, 32'h03);            // reference source
    pulse(1, 2);
    bus_read(8'h18, 32'd3, "R7");
    pulse(0, 1);
    bus_read(8'h18, 32'd2, "R7");

    bus_write(8'h10, 32'h05);            // one-shot, osc
    bus_write(8'h18, 32'd1);
    pulse(1, 1);
    bus_read(8'h18, 32'd0, "R9");
    pulse(1, 1);
    bus_read(8'h18, 32'd0, "R9");
    bus_read(8'h10, 32'h04, "R9");
    bus_read(8'h04, 32'h1, "R4");
    pulse(1, 2);
    bus_read(8'h18, 32'd0, "R9");
    bus_write(8'h04, 32'h1);

    bus_write(8'h10, 32'h05);
    write_and_pulse(8'h18, 32'd9);
    bus_read(8'h18, 32'd9, "R10");
    pulse(1, 1);
    bus_read(8'h18, 32'd8, "R2");

    bus_write(8'h18, 32'd0);
    write_and_pulse(8'h04, 32'h1);       // expiry against clear
    bus_read(8'h04, 32'h1, "R5");

    drain();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule